// File: doc/BRIEF.md
# Two-phase microstepping translator

This block turns a step-and-direction command stream into current commands for the two windings of a bipolar stepper motor. It keeps a 5-bit electrical-angle index covering one full electrical cycle in 32 eighth-step positions. Each rising edge on the step input moves that index forward or backward by one step of the selected resolution: full, half, quarter or eighth step.

From the index it derives a 4-bit current magnitude and a polarity bit for each winding. Winding A follows a sine weighting and winding B follows a cosine weighting. These codes are handed to the PWM current chopper that follows. A home flag marks the 45-degree point of the cycle, where both windings carry about 71% of full-scale current.

The step input is asynchronous. It passes through two flip-flops before an edge detector samples it. Reset and sleep both block movement, and the enable input only zeroes the current codes.

Top module: `stepper_xlat`

## Requirements
- R1: While rst_n is low, and directly after it rises, the index is 4: mag_a = 11, mag_b = 11, pol_a = 1, pol_b = 1 and at_home = 1.
- R2: Each rising edge of step_in changes the index, modulo 32, by the amount that res_sel selects: 00 gives 8 (full step), 01 gives 4 (half step), 10 gives 2 (quarter step) and 11 gives 1 (eighth step).
- R3: When dir_in is 1, a step adds to the index; when dir_in is 0, a step subtracts from it.
- R4: Take k as the index and theta as k·π/16. Then mag_a = round(15·|sin θ|) and mag_b = round(15·|cos θ|). This gives the quarter-wave codes 0, 3, 6, 8, 11, 12, 14, 15, 15.
- R5: pol_a is 1 for indices 0 to 15 and 0 otherwise. pol_b is 1 for indices 0 to 7 and 24 to 31 and 0 otherwise.
- R6: at_home is 1 exactly when the index is 4.
- R7: One clock after res_sel changes, the index lies on a valid point for the new resolution. The new index is formed as follows:
  - full step: the low three bits become 100;
  - half step: the low two bits are cleared;
  - quarter step: bit 0 is cleared;
  - eighth step: the index is unchanged.
- R8: While sleep_in is 1, step edges are ignored, the index does not change, and mag_a and mag_b are 0.
- R9: While en_in is 0, mag_a and mag_b are 0, but step edges still move the index.
- R10: A rising edge of step_in takes effect on the third rising clock edge after it. A falling edge of step_in has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset to the home position |
| step_in | input | 1 | Asynchronous step request; it acts on its rising edge |
| dir_in | input | 1 | 1 moves forward, 0 moves backward |
| res_sel | input | 2 | Resolution select: 00 full, 01 half, 10 quarter, 11 eighth |
| en_in | input | 1 | When 0, the current magnitudes are forced to zero |
| sleep_in | input | 1 | When 1, movement is frozen and the magnitudes are zero |
| mag_a | output | 4 | Winding A current magnitude (sine) |
| pol_a | output | 1 | Winding A polarity, 1 for positive |
| mag_b | output | 4 | Winding B current magnitude (cosine) |
| pol_b | output | 1 | Winding B polarity, 1 for positive |
| at_home | output | 1 | High at the home index |

## Verification
The checker watches the following properties on every clock cycle:
- the index is 4 on leaving reset;
- the index never moves by more than one full step per clock;
- the index stays aligned whenever the resolution has been steady for a cycle;
- the index is frozen during sleep;
- at the home flag, the two windings carry equal positive current.

Only the bench scenarios can show the remaining behaviour. This covers the exact step sizes and their direction, the sine and cosine codes at every index, the three-clock step latency, and the fact that falling step edges do nothing. It also covers current masking under enable and sleep, which the bench checks against a model index of its own.

// File: rtl/stepper_xlat.sv
module stepper_xlat #(
  parameter int HOME_IDX = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_in,
  input  logic       dir_in,
  input  logic [1:0] res_sel,
  input  logic       en_in,
  input  logic       sleep_in,
  output logic [3:0] mag_a,
  output logic       pol_a,
  output logic [3:0] mag_b,
  output logic       pol_b,
  output logic       at_home
);
  localparam logic [4:0] HOME = 5'(HOME_IDX);

  logic [2:0] sync_q;
  logic [4:0] idx;
  logic [4:0] base;
  logic [4:0] incr;
  logic       step_rise;

  function automatic logic [3:0] qwave(input logic [3:0] k);
    case (k)
      4'd0: qwave = 4'd0;
      4'd1: qwave = 4'd3;
      4'd2: qwave = 4'd6;
      4'd3: qwave = 4'd8;
      4'd4: qwave = 4'd11;
      4'd5: qwave = 4'd12;
      4'd6: qwave = 4'd14;
      default: qwave = 4'd15;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], step_in};

  assign step_rise = sync_q[1] & ~sync_q[2];

  always_comb begin
    case (res_sel)
      2'b00:   base = {idx[4:3], 3'b100};
      2'b01:   base = {idx[4:2], 2'b00};
      2'b10:   base = {idx[4:1], 1'b0};
      default: base = idx;
    endcase
    incr = 5'd8 >> res_sel;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             idx <= HOME;
    else if (!sleep_in) begin
      if (step_rise)        idx <= dir_in ? base + incr : base - incr;
      else                  idx <= base;
    end

  logic [3:0] fwd_k, rev_k;
  assign fwd_k = {1'b0, idx[2:0]};
  assign rev_k = 4'd8 - fwd_k;

  logic live;
  assign live    = en_in & ~sleep_in;
  assign mag_a   = live ? qwave(idx[3] ? rev_k : fwd_k) : 4'd0;
  assign mag_b   = live ? qwave(idx[3] ? fwd_k : rev_k) : 4'd0;
  assign pol_a   = ~idx[4];
  assign pol_b   = ~(idx[4] ^ idx[3]);
  assign at_home = (idx == HOME);
endmodule

module stepper_xlat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] res_sel,
  input logic       sleep_in,
  input logic       en_in,
  input logic [4:0] idx,
  input logic [3:0] mag_a,
  input logic [3:0] mag_b,
  input logic       pol_a,
  input logic       pol_b,
  input logic       at_home
);
  function automatic logic aligned(input logic [4:0] i, input logic [1:0] r);
    case (r)
      2'b00:   aligned = (i[2:0] == 3'b100);
      2'b01:   aligned = (i[1:0] == 2'b00);
      2'b10:   aligned = (i[0] == 1'b0);
      default: aligned = 1'b1;
    endcase
  endfunction

  // R1
  home_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (idx == 5'd4) && at_home);

  // R2
  bounded_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (5'(idx - $past(idx)) <= 5'd8) || (5'(idx - $past(idx)) >= 5'd24));

  // R6
  home_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_home && en_in && !sleep_in) |-> (mag_a == mag_b) && pol_a && pol_b && (mag_a != 4'd0));

  // R7
  aligned_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_sel == $past(res_sel)) |-> aligned(idx, res_sel));

  // R8
  sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_in |=> $stable(idx));
endmodule

bind stepper_xlat stepper_xlat_chk chk (
  .clk(clk), .rst_n(rst_n), .res_sel(res_sel), .sleep_in(sleep_in), .en_in(en_in),
  .idx(idx), .mag_a(mag_a), .mag_b(mag_b), .pol_a(pol_a), .pol_b(pol_b),
  .at_home(at_home)
);

// File: tb/stepper_xlat_test.sv
`timescale 1ns/1ps
module stepper_xlat_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_in = 1'b0;
  logic       dir_in = 1'b1;
  logic [1:0] res_sel = 2'b11;
  logic       en_in = 1'b1;
  logic       sleep_in = 1'b0;
  logic [3:0] mag_a, mag_b;
  logic       pol_a, pol_b, at_home;

  int checks = 0;
  int errors = 0;
  int model = 4;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stepper_xlat uut (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .dir_in(dir_in), .res_sel(res_sel),
    .en_in(en_in), .sleep_in(sleep_in), .mag_a(mag_a), .pol_a(pol_a),
    .mag_b(mag_b), .pol_b(pol_b), .at_home(at_home)
  );

  function automatic int exp_mag(int i, bit use_cos);
    real th, v;
    th = i * 3.14159265358979 / 16.0;
    v = use_cos ? $cos(th) : $sin(th);
    if (v < 0.0) v = -v;
    return $rtoi(15.0 * v + 0.5);
  endfunction

  function automatic int snap(int i, logic [1:0] r);
    case (r)
      2'b00:   return (i & 24) | 4;
      2'b01:   return i & 28;
      2'b10:   return i & 30;
      default: return i;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (index %0d)", req, act, exp, model);
    end
  endtask

  task automatic check_out(string req);
    bit live;
    live = en_in && !sleep_in;
    chk({req, " R4 mag_a"}, mag_a, live ? exp_mag(model, 0) : 0);
    chk({req, " R4 mag_b"}, mag_b, live ? exp_mag(model, 1) : 0);
    chk({req, " R5 pol_a"}, pol_a, (model < 16) ? 1 : 0);
    chk({req, " R5 pol_b"}, pol_b, (model < 8 || model >= 24) ? 1 : 0);
    chk({req, " R6 at_home"}, at_home, (model == 4) ? 1 : 0);
  endtask

  task automatic waitn(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_step(bit d, string req);
    dir_in = d;
    step_in = 1'b1;
    waitn(5);
    if (!sleep_in) model = (model + (d ? (8 >> res_sel) : 32 - (8 >> res_sel))) % 32;
    check_out(req);
    step_in = 1'b0;
    waitn(4);
    check_out({req, " R10 fall"});
  endtask

  task automatic set_res(logic [1:0] r);
    res_sel = r;
    waitn(2);
    model = snap(model, r);
    check_out("R7 snap");
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    waitn(3);
    check_out("R1 in reset");
    rst_n = 1'b1;
    waitn(1);
    check_out("R1 after release");

    // R10 latency: unchanged after two edges, moved on the third
    step_in = 1'b1;
    dir_in = 1'b1;
    waitn(2);
    check_out("R10 before third edge");
    waitn(1);
    model = 5;
    check_out("R10 third edge");
    step_in = 1'b0;
    waitn(4);

    // R2/R3 each resolution, both directions
    for (int r = 3; r >= 0; r--) begin
      set_res(2'(r));
      do_step(1'b1, "R2 R3 fwd");
      do_step(1'b0, "R3 rev");
    end

    // R2 full-step wrap through the cycle
    for (int k = 0; k < 5; k++) do_step(1'b1, "R2 wrap");
    for (int k = 0; k < 5; k++) do_step(1'b0, "R2 wrap rev");

    // R4/R5 sweep all 32 positions at eighth step
    set_res(2'b11);
    for (int k = 0; k < 32; k++) do_step(1'b1, "R4 R5 sweep");

    // R8 sleep ignores steps and zeroes currents
    sleep_in = 1'b1;
    waitn(1);
    do_step(1'b1, "R8 sleep");
    sleep_in = 1'b0;
    waitn(1);
    check_out("R8 after sleep");

    // R9 enable low zeroes currents but still moves
    en_in = 1'b0;
    waitn(1);
    do_step(1'b1, "R9 disabled");
    en_in = 1'b1;
    waitn(1);
    check_out("R9 re-enabled");

    // Random mix
    for (int n = 0; n < 300; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 6) do_step(1'($urandom_range(0, 1)), "R2 R3 random");
      else if (op < 8) set_res(2'($urandom_range(0, 3)));
      else if (op == 8) begin
        sleep_in = 1'b1;
        waitn(1);
        do_step(1'($urandom_range(0, 1)), "R8 random");
        sleep_in = 1'b0;
        waitn(1);
      end else begin
        en_in = 1'b0;
        waitn(1);
        do_step(1'($urandom_range(0, 1)), "R9 random");
        en_in = 1'b1;
        waitn(1);
      end
    end

    // R1 mid-run reset
    rst_n = 1'b0;
    #1;
    model = 4;
    check_out("R1 async");
    waitn(2);
    rst_n = 1'b1;
    waitn(1);
    check_out("R1 release again");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule